// File: doc/BRIEF.md
# StreamID Span-Match Event Filter

This block decides, for each of a bank of event counters, whether an incoming event pulse should be counted. Each event arrives with an event-type code and the StreamID of the transaction that raised it. Every counter slot holds a 32-bit type word, carrying an event code and a span flag, and a 32-bit match word. A slot accepts an event when the codes agree and the StreamID passes the slot's filter. The block sits between an event source and the counters, and its output is one qualified pulse per slot.

The StreamID filter has two forms. With the span flag clear, every implemented StreamID bit must equal the match word. With the flag set, the match word describes its own don't-care field. The lowest zero bit of the match word, and every one bit below it, are ignored. The bits above that zero must match. A match word of all ones ignores the whole StreamID, which is how filtering is switched off. A global mode input makes slot 0's span flag and match word the single filter for every slot. Each slot still compares the event code from its own type word.

Top module: `sidf_top`

## Requirements
- R1: With the effective span flag clear, a slot accepts an event only when all SIDW bits of the event StreamID equal bits SIDW-1..0 of the effective match word.
- R2: With the effective span flag set, let p be the index of the lowest zero bit of the match word. StreamID bits p down to 0 are ignored, and bits SIDW-1 down to p+1 must equal the match word.
- R3: With span set and match word 0x42, StreamIDs 0x42 and 0x43 are accepted, and 0x40, 0x41 and 0x44 are rejected.
- R4: With span set and a match word of 0xFFFFFFFF, every StreamID is accepted.
- R5: With span set, when bits SIDW-1..0 of the match word are all ones, every StreamID is accepted, whatever the bits above SIDW hold.
- R6: With span clear, match-word bits at SIDW and above have no effect on the result.
- R7: In the type word, bit 29 is the span flag and bits EVW-1..0 are the event code. A slot fires only when its code equals `evt_code`, in both normal and global mode.
- R8: With `global_mode` high, every slot filters the StreamID with slot 0's span flag and match word. The slot's own span flag and match word are not used.
- R9: `qual_evt[j]` goes high in the cycle after a clock edge at which `evt_valid` was high and slot j accepted the event. The StreamID and code are sampled on that same edge. Without `evt_valid`, no slot fires.
- R10: While `rst_n` is low, `qual_evt` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| global_mode | input | 1 | Slot 0's filter governs every slot |
| evt_valid | input | 1 | Event pulse |
| evt_code | input | EVW | Event-type code of the pulse |
| evt_sid | input | SIDW | StreamID of the causing transaction |
| cfg_type | input | NCNT*32 | Per-slot type words, slot j at bits 32j+31..32j |
| cfg_match | input | NCNT*32 | Per-slot match words, slot j at bits 32j+31..32j |
| qual_evt | output | NCNT | Registered qualified pulse per slot |

## Verification
The filtering of a slot and the event-code selection of a different slot act on the same event, in the same cycle. A single pulse can be accepted by one slot, rejected by another for its StreamID, and ignored by a third for its code. The bench provokes this by loading all slots with the same code but different filters. It also loads slots with a mix of codes, then sends one event. The full output vector is compared against a model in a scoreboard, so an error in any one slot shows up in the bit of that slot. In global mode, the same single event has to give equal results on every slot whose code matches.

// File: rtl/sidf_pkg.sv
package sidf_pkg;

  // Width of one configuration word (type word and match word).
  localparam int unsigned CFG_W    = 32;
  // Bit of the type word that selects span matching.
  localparam int unsigned SPAN_POS = 29;

  // Marks the don't-care field of a span match word. The result has a one at
  // the lowest zero bit of m and at every bit below it. When m is all ones,
  // the carry runs out of the top and the result is all ones.
  function automatic logic [CFG_W-1:0] span_ignore(input logic [CFG_W-1:0] m);
    return m ^ (m + 32'd1);
  endfunction

  // Nonzero when a StreamID disagrees with the match value on a cared bit.
  function automatic logic [CFG_W-1:0] sid_diff(input logic [CFG_W-1:0] sid,
                                                input logic [CFG_W-1:0] match,
                                                input logic [CFG_W-1:0] care);
    return (sid ^ match) & care;
  endfunction

endpackage

// File: rtl/sidf_care_decode.sv
module sidf_care_decode
  import sidf_pkg::*;
#(
  parameter int unsigned SIDW = 16
) (
  input  logic             span_en,
  input  logic [CFG_W-1:0] match_val,
  output logic [SIDW-1:0]  care_mask
);

  // Don't-care field derived from the match value itself.
  logic [SIDW-1:0] ign_field;

  assign ign_field = SIDW'(span_ignore(match_val));
  assign care_mask = span_en ? ~ign_field : '1;

endmodule

// File: rtl/sidf_slot.sv
module sidf_slot
  import sidf_pkg::*;
#(
  parameter int unsigned SIDW = 16,
  parameter int unsigned EVW  = 8
) (
  input  logic [EVW-1:0]  evt_code,
  input  logic [SIDW-1:0] evt_sid,
  input  logic [EVW-1:0]  slot_code,
  input  logic [SIDW-1:0] match_low,
  input  logic [SIDW-1:0] care_mask,
  output logic            code_eq,
  output logic            sid_eq,
  output logic            slot_hit
);

  logic [CFG_W-1:0] diff_w;

  assign diff_w   = sid_diff(CFG_W'(evt_sid), CFG_W'(match_low), CFG_W'(care_mask));
  assign code_eq  = (evt_code == slot_code);
  assign sid_eq   = (diff_w == '0);
  assign slot_hit = code_eq & sid_eq;

endmodule

// File: rtl/sidf_pulse_reg.sv
module sidf_pulse_reg #(
  parameter int unsigned NCNT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCNT-1:0] d_fire,
  output logic [NCNT-1:0] q_fire
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_fire <= '0;
    else        q_fire <= d_fire;
  end

endmodule

// File: rtl/sidf_top.sv
module sidf_top
  import sidf_pkg::*;
#(
  parameter int unsigned NCNT = 4,
  parameter int unsigned SIDW = 16,
  parameter int unsigned EVW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  global_mode,
  input  logic                  evt_valid,
  input  logic [EVW-1:0]        evt_code,
  input  logic [SIDW-1:0]       evt_sid,
  input  logic [NCNT*CFG_W-1:0] cfg_type,
  input  logic [NCNT*CFG_W-1:0] cfg_match,
  output logic [NCNT-1:0]       qual_evt
);

  localparam int unsigned CFG_BITS = NCNT * CFG_W;

  // Shared filter for global mode: slot 0's settings.
  logic             base_span;
  logic [CFG_W-1:0] base_match;
  logic [NCNT-1:0]  slot_hit;
  logic [NCNT-1:0]  slot_code_eq;
  logic [NCNT-1:0]  slot_sid_eq;
  logic [NCNT-1:0]  fire_now;

  assign base_span  = cfg_type[SPAN_POS];
  assign base_match = cfg_match[CFG_W-1:0];

  for (genvar j = 0; j < NCNT; j++) begin : g_slot
    logic [CFG_W-1:0] own_type;
    logic [CFG_W-1:0] own_match;
    logic             eff_span;
    logic [CFG_W-1:0] eff_match;
    logic [SIDW-1:0]  care;
    logic             unused_type_bits;

    assign own_type  = cfg_type[j*CFG_W +: CFG_W];
    assign own_match = cfg_match[j*CFG_W +: CFG_W];
    assign eff_span  = global_mode ? base_span  : own_type[SPAN_POS];
    assign eff_match = global_mode ? base_match : own_match;
    assign unused_type_bits = ^{own_type[CFG_W-1:SPAN_POS+1], own_type[SPAN_POS-1:EVW]};

    sidf_care_decode #(.SIDW(SIDW)) u_care (
      .span_en   (eff_span),
      .match_val (eff_match),
      .care_mask (care)
    );

    sidf_slot #(.SIDW(SIDW), .EVW(EVW)) u_slot (
      .evt_code  (evt_code),
      .evt_sid   (evt_sid),
      .slot_code (own_type[EVW-1:0]),
      .match_low (eff_match[SIDW-1:0]),
      .care_mask (care),
      .code_eq   (slot_code_eq[j]),
      .sid_eq    (slot_sid_eq[j]),
      .slot_hit  (slot_hit[j])
    );

    // R1: exact mode rejects any StreamID differing from the match word.
    assert_exact_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !global_mode && !cfg_type[j*CFG_W + SPAN_POS] &&
       evt_code == cfg_type[j*CFG_W +: EVW] &&
       evt_sid != cfg_match[j*CFG_W +: SIDW]) |=> !qual_evt[j]);

    // R4: an all-ones span match word accepts any StreamID.
    assert_allones_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !global_mode && cfg_type[j*CFG_W + SPAN_POS] &&
       (&cfg_match[j*CFG_W +: CFG_W]) &&
       evt_code == cfg_type[j*CFG_W +: EVW]) |=> qual_evt[j]);

    // R7: a code mismatch never fires the slot.
    assert_code_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_code != cfg_type[j*CFG_W +: EVW]) |=> !qual_evt[j]);

    // R8: in global mode, slots whose codes agree with slot 0 give equal results.
    assert_global_share_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && global_mode &&
       evt_code == cfg_type[j*CFG_W +: EVW] &&
       evt_code == cfg_type[EVW-1:0]) |=> (qual_evt[j] == qual_evt[0]));
  end

  assign fire_now = {NCNT{evt_valid}} & slot_hit;

  sidf_pulse_reg #(.NCNT(NCNT)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_fire (fire_now),
    .q_fire (qual_evt)
  );

  // R9: without an event pulse, nothing fires on the next cycle.
  assert_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> (qual_evt == '0));

  // R9: an accepted event pulse appears exactly one cycle later.
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && slot_code_eq[0] && slot_sid_eq[0]) |=> qual_evt[0]);

  // R10: reset clears every pulse.
  always_comb begin
    if (!rst_n) assert_reset_clear_R10: assert (qual_evt == '0);
  end

  logic unused_cfg_width;
  assign unused_cfg_width = ^CFG_BITS;

endmodule

// File: tb/sidf_top_test.sv
module sidf_top_test;
  localparam int NCNT = 4;
  localparam int SIDW = 16;
  localparam int EVW  = 8;

  typedef struct {
    logic [NCNT-1:0] exp;
    string           tag;
  } item_t;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  global_mode = 1'b0;
  logic                  evt_valid = 1'b0;
  logic [EVW-1:0]        evt_code = '0;
  logic [SIDW-1:0]       evt_sid = '0;
  logic [NCNT*32-1:0]    cfg_type;
  logic [NCNT*32-1:0]    cfg_match;
  logic [NCNT-1:0]       qual_evt;

  logic [31:0] ty [NCNT];
  logic [31:0] mt [NCNT];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  item_t sbq[$];

  always #2 clk = ~clk;

  always_comb begin
    for (int j = 0; j < NCNT; j++) begin
      cfg_type[j*32 +: 32]  = ty[j];
      cfg_match[j*32 +: 32] = mt[j];
    end
  end

  sidf_top #(.NCNT(NCNT), .SIDW(SIDW), .EVW(EVW)) uut (
    .clk(clk), .rst_n(rst_n), .global_mode(global_mode),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_sid(evt_sid),
    .cfg_type(cfg_type), .cfg_match(cfg_match), .qual_evt(qual_evt)
  );

  // Reference filter: walk up to the first zero, then compare the rest.
  function automatic bit ref_pass(bit span, logic [31:0] m, logic [SIDW-1:0] sid);
    int first_zero;
    if (!span) return sid == m[SIDW-1:0];
    first_zero = SIDW;
    for (int i = SIDW - 1; i >= 0; i--) if (m[i] == 1'b0) first_zero = i;
    for (int i = first_zero + 1; i < SIDW; i++) if (sid[i] != m[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] tword(bit span, logic [EVW-1:0] code);
    return (32'(span) << 29) | 32'(code);
  endfunction

  task automatic send(bit v, logic [EVW-1:0] code, logic [SIDW-1:0] sid, string tag);
    item_t it;
    evt_valid = v;
    evt_code  = code;
    evt_sid   = sid;
    for (int j = 0; j < NCNT; j++) begin
      bit sp;
      logic [31:0] m;
      sp = global_mode ? ty[0][29] : ty[j][29];
      m  = global_mode ? mt[0] : mt[j];
      it.exp[j] = v && (ty[j][EVW-1:0] == code) && ref_pass(sp, m, sid);
    end
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compare each registered result one edge after its stimulus.
  always @(posedge clk) begin
    item_t got;
    #1;
    if (rst_n && sbq.size() > 0) begin
      got = sbq.pop_front();
      checks++;
      if (qual_evt !== got.exp) begin
        failures++;
        $display("FAIL %s: qual_evt actual=%b expected=%b", got.tag, qual_evt, got.exp);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NCNT; j++) begin ty[j] = '0; mt[j] = '0; end
    repeat (3) @(negedge clk);
    // R10: reset holds all pulses low, even with an event presented.
    evt_valid = 1'b1;
    @(negedge clk);
    checks++;
    if (qual_evt !== '0) begin
      failures++;
      $display("FAIL R10: qual_evt actual=%b expected=%b", qual_evt, {NCNT{1'b0}});
    end
    evt_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // Mixed filters, one code: R1 exact, R6 upper bits, R3 span 0x42, R2 span 0xF7.
    ty[0] = tword(0, 8'h03); mt[0] = 32'h0000_1234;
    ty[1] = tword(0, 8'h03); mt[1] = 32'hABCD_1234;
    ty[2] = tword(1, 8'h03); mt[2] = 32'h0000_0042;
    ty[3] = tword(1, 8'h03); mt[3] = 32'h0000_00F7;
    send(1, 8'h03, 16'h1234, "R1 R6 exact hit");
    send(1, 8'h03, 16'h1235, "R1 exact low-bit miss");
    send(1, 8'h03, 16'h9234, "R1 exact high-bit miss");
    send(1, 8'h03, 16'h0042, "R3 span 0x42");
    send(1, 8'h03, 16'h0043, "R3 span 0x43");
    send(1, 8'h03, 16'h0041, "R3 span 0x41 reject");
    send(1, 8'h03, 16'h0040, "R3 span 0x40 reject");
    send(1, 8'h03, 16'h0044, "R3 span 0x44 reject");
    send(1, 8'h03, 16'h00F0, "R2 span low field 0xF0");
    send(1, 8'h03, 16'h00FF, "R2 span low field 0xFF");
    send(1, 8'h03, 16'h00E5, "R2 span upper miss");
    send(1, 8'h03, 16'h01F3, "R2 span high bit miss");

    // R9: no pulse without evt_valid, even when every filter matches.
    send(0, 8'h03, 16'h1234, "R9 no event");

    // R4 and R5: all-ones match words and all-ones implemented field.
    ty[0] = tword(1, 8'h05); mt[0] = 32'hFFFF_FFFF;
    ty[1] = tword(1, 8'h05); mt[1] = 32'h0000_FFFF;
    ty[2] = tword(1, 8'h05); mt[2] = 32'h5A00_FFFF;
    ty[3] = tword(0, 8'h05); mt[3] = 32'hFFFF_FFFF;
    send(1, 8'h05, 16'h0000, "R4 R5 sid 0");
    send(1, 8'h05, 16'hBEEF, "R4 R5 sid BEEF");
    send(1, 8'h05, 16'hFFFF, "R4 R5 sid FFFF");

    // R7: codes differ per slot; only the matching slot fires.
    ty[0] = tword(1, 8'h01); mt[0] = 32'hFFFF_FFFF;
    ty[1] = tword(1, 8'h02); mt[1] = 32'hFFFF_FFFF;
    ty[2] = tword(0, 8'h03); mt[2] = 32'h0000_0777;
    ty[3] = tword(1, 8'h04); mt[3] = 32'hFFFF_FFFF;
    send(1, 8'h02, 16'h0777, "R7 code selects slot 1");
    send(1, 8'h03, 16'h0777, "R7 code selects slot 2");
    send(1, 8'h09, 16'h0777, "R7 unknown code");

    // R8: global mode uses slot 0's span 0x42 filter everywhere.
    ty[0] = tword(1, 8'h03); mt[0] = 32'h0000_0042;
    ty[1] = tword(0, 8'h03); mt[1] = 32'h0000_1111;
    ty[2] = tword(1, 8'h03); mt[2] = 32'hFFFF_FFFF;
    ty[3] = tword(1, 8'h06); mt[3] = 32'hFFFF_FFFF;
    global_mode = 1'b1;
    send(1, 8'h03, 16'h0043, "R8 global pass");
    send(1, 8'h03, 16'h1111, "R8 global reject own match");
    send(1, 8'h06, 16'h0042, "R8 R7 global code slot 3");
    global_mode = 1'b0;
    send(1, 8'h03, 16'h1111, "R8 back to own filters");

    // Mixed random traffic across both match forms (R1, R2).
    for (int k = 0; k < 200; k++) begin
      for (int j = 0; j < NCNT; j++) begin
        ty[j] = tword(1'($urandom), 8'($urandom_range(0, 2)));
        mt[j] = $urandom;
        if (k % 3 == 0) mt[j][SIDW-1:0] = 16'($urandom_range(0, 7)) | 16'h00F0;
      end
      global_mode = ($urandom_range(0, 4) == 0);
      send(1'($urandom_range(0, 5) != 0), 8'($urandom_range(0, 2)),
           (k % 3 == 0) ? 16'($urandom_range(0, 255)) : 16'($urandom),
           "R1 R2 random");
    end
    evt_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule